// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block is the local reservation monitor of one processor. It supports load-linked / store-conditional synchronization. It takes a request stream in which every request carries an operation code and a physical address. The operation is a load-exclusive, a store-exclusive, an ordinary store or an explicit clear. The monitor keeps one reservation tag, made from the upper address bits, and a single flag that tells whether an exclusive reservation is held. The flag gives two states: Open and Exclusive.

For each store-exclusive the monitor answers in the same cycle. The answer is a pass/fail status and a memory write-enable that lets the conditional store through or blocks it. The reservation covers a granule of `2^GRAN_SHIFT` bytes, with `GRAN_SHIFT` from 3 to 11. That gives 2 to 512 words of 32 bits. Two policy parameters settle the cases an implementation may choose: whether a mismatched store-exclusive still writes memory, and whether an ordinary store inside the granule kills the reservation. A separate context-switch clear input drops the reservation. While that input is high it also holds off the request stream.

Requests use a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while `ctx_clr` is high. A request offered during that time is not taken, and the source must hold it until `req_ready` returns. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse in the cycle the store-exclusive is taken.

Top module: `excl_mon`

## Requirements
- R1: After synchronous reset the monitor is Open (`excl_held`=0) and the stored tag is zero. A store-exclusive to address 0 right after reset therefore fails.
- R2: Operation codes are `req_op` 0 = load-exclusive, 1 = store-exclusive, 2 = ordinary store, 3 = clear. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` equals the inverse of `ctx_clr`. A request that is not taken changes nothing and produces no response.
- R3: A taken load-exclusive sets `excl_held` in the next cycle and records tag `req_addr[ADDR_W-1:GRAN_SHIFT]`. Two addresses hit the reservation when they share this tag.
- R4: A taken store-exclusive that is in Exclusive state and hits the tag gives `rsp_valid`=1, `rsp_fail`=0 and `mem_wr_en`=1 in the same cycle. The monitor is Open from the next cycle.
- R5: A taken store-exclusive that is in Exclusive state and misses the tag gives `rsp_fail`=1 and `mem_wr_en`=`MISMATCH_WRITES`. The monitor is Open from the next cycle.
- R6: A taken store-exclusive in Open state gives `rsp_fail`=1 and `mem_wr_en`=0, and the monitor stays Open.
- R7: A taken ordinary store that misses the tag leaves the state and the tag unchanged.
- R8: A taken ordinary store that hits the tag while Exclusive makes the monitor Open in the next cycle when `PLAIN_ST_CLEARS`=1. When `PLAIN_ST_CLEARS`=0 it leaves the state unchanged.
- R9: `ctx_clr` high forces Open in the next cycle, whatever the request inputs are.
- R10: A load-exclusive taken while Exclusive replaces the tag with the new address's tag.
- R11: A taken clear operation makes the monitor Open in the next cycle.
- R12: `mem_wr_en` and `rsp_fail` are never high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctx_clr | input | 1 | Context-switch clear of the reservation |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (low while `ctx_clr` is high) |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | ADDR_W | Physical address of the request |
| rsp_valid | output | 1 | Store-exclusive response valid this cycle |
| rsp_fail | output | 1 | Store-exclusive status: 0 pass, 1 fail |
| mem_wr_en | output | 1 | Allows the store-exclusive's memory update |
| excl_held | output | 1 | Monitor is in Exclusive state |

## Verification
The assertions watch every cycle. They check the state moves after load-exclusive, store-exclusive, clear and `ctx_clr`, the handshake gating, and the tag capture. They also check that a response from Open state never writes and that the write and fail outputs stay inside a response. The bench's scenarios are needed for the granule edges: which addresses share a tag at a given `GRAN_SHIFT`, the outcome of each policy parameter setting, tag replacement by a second load-exclusive, and a random mix of requests. These are compared against a behavioural model that runs on two instances with different granule and policy settings.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_LDEX = 2'd0,
    OP_STEX = 2'd1,
    OP_ST   = 2'd2,
    OP_CLR  = 2'd3
  } mon_op_e;
endpackage

// File: rtl/excl_tag_cmp.sv
module excl_tag_cmp #(
  parameter int ADDR_W     = 32,
  parameter int GRAN_SHIFT = 4,
  localparam int TAG_W     = ADDR_W - GRAN_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  rsv_tag,
  output logic [TAG_W-1:0]  cur_tag,
  output logic              hit
);
  logic unused_low;
  assign unused_low = ^addr[GRAN_SHIFT-1:0];
  assign cur_tag    = addr[ADDR_W-1:GRAN_SHIFT];
  assign hit        = (cur_tag == rsv_tag);
endmodule

// File: rtl/excl_resv_fsm.sv
module excl_resv_fsm
  import excl_mon_pkg::*;
#(
  parameter int TAG_W           = 28,
  parameter bit PLAIN_ST_CLEARS = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_force,
  input  logic             acc,
  input  mon_op_e          op,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic             hit,
  output logic             excl,
  output logic [TAG_W-1:0] rsv_tag
);
  logic st_kill;

  generate
    if (PLAIN_ST_CLEARS) begin : g_st_kills
      assign st_kill = hit;
    end else begin : g_st_keeps
      assign st_kill = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      excl    <= 1'b0;
      rsv_tag <= '0;
    end else if (clr_force) begin
      excl <= 1'b0;
    end else if (acc) begin
      unique case (op)
        OP_LDEX: begin
          excl    <= 1'b1;
          rsv_tag <= cur_tag;
        end
        OP_STEX: excl <= 1'b0;
        OP_ST:   if (st_kill) excl <= 1'b0;
        OP_CLR:  excl <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_LDEX_TAKES_TAG: assert property (@(posedge clk) disable iff (rst)
    (acc && !clr_force && op == OP_LDEX) |=> (excl && rsv_tag == $past(cur_tag))); // R3
  AST_STEX_OPENS: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_STEX) |=> !excl); // R4
  AST_CLR_OP_OPENS: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_CLR) |=> !excl); // R11
  AST_FORCE_OPENS: assert property (@(posedge clk) disable iff (rst)
    clr_force |=> !excl); // R9
  AST_MISS_ST_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (acc && !clr_force && op == OP_ST && !hit) |=> ($stable(excl) && $stable(rsv_tag))); // R7
endmodule

// File: rtl/excl_sc_resp.sv
module excl_sc_resp
  import excl_mon_pkg::*;
#(
  parameter bit MISMATCH_WRITES = 1'b0
) (
  input  logic    acc,
  input  mon_op_e op,
  input  logic    excl,
  input  logic    hit,
  output logic    rsp_valid,
  output logic    rsp_fail,
  output logic    mem_wr_en
);
  logic pass;
  logic miss_wr;

  generate
    if (MISMATCH_WRITES) begin : g_miss_writes
      assign miss_wr = excl & ~hit;
    end else begin : g_miss_blocks
      assign miss_wr = 1'b0;
    end
  endgenerate

  always_comb begin
    rsp_valid = acc && (op == OP_STEX);
    pass      = excl && hit;
    rsp_fail  = rsp_valid && !pass;
    mem_wr_en = rsp_valid && (pass || miss_wr);
  end
endmodule

// File: rtl/excl_mon.sv
module excl_mon
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int GRAN_SHIFT      = 4,
  parameter bit MISMATCH_WRITES = 1'b0,
  parameter bit PLAIN_ST_CLEARS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctx_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_fail,
  output logic              mem_wr_en,
  output logic              excl_held
);
  localparam int TAG_W = ADDR_W - GRAN_SHIFT;

  mon_op_e          op;
  logic             acc;
  logic [TAG_W-1:0] cur_tag;
  logic [TAG_W-1:0] rsv_tag;
  logic             hit;

  assign op        = mon_op_e'(req_op);
  assign req_ready = ~ctx_clr;
  assign acc       = req_valid & req_ready;

  excl_tag_cmp #(.ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT)) u_cmp (
    .addr(req_addr), .rsv_tag(rsv_tag), .cur_tag(cur_tag), .hit(hit)
  );

  excl_resv_fsm #(.TAG_W(TAG_W), .PLAIN_ST_CLEARS(PLAIN_ST_CLEARS)) u_fsm (
    .clk(clk), .rst(rst), .clr_force(ctx_clr), .acc(acc), .op(op),
    .cur_tag(cur_tag), .hit(hit), .excl(excl_held), .rsv_tag(rsv_tag)
  );

  excl_sc_resp #(.MISMATCH_WRITES(MISMATCH_WRITES)) u_resp (
    .acc(acc), .op(op), .excl(excl_held), .hit(hit),
    .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .mem_wr_en(mem_wr_en)
  );

  AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
    ctx_clr |-> (!req_ready && !rsp_valid)); // R2
  AST_OPEN_NEVER_WRITES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !excl_held) |-> (rsp_fail && !mem_wr_en)); // R6
  AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !excl_held) |=> !excl_held); // R6
  AST_OUT_IN_RSP: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en || rsp_fail) |-> rsp_valid); // R12
  AST_PASS_WRITES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fail) |-> (mem_wr_en && excl_held)); // R4
  AST_RESET_OPEN: assert property (@(posedge clk)
    rst |=> !excl_held); // R1
endmodule

// File: tb/sim_excl_mon.sv
module sim_excl_mon;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctx_clr;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic        rdy [2];
  logic        rv  [2];
  logic        rf  [2];
  logic        we  [2];
  logic        eh  [2];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state and per-instance settings
  bit     m_excl [2];
  longint m_tag  [2];
  int     gs     [2] = '{4, 3};
  bit     mw     [2] = '{1'b0, 1'b1};
  bit     psc    [2] = '{1'b1, 1'b0};

  always #10 clk = ~clk; // 50 MHz

  excl_mon u0 (
    .clk(clk), .rst(rst), .ctx_clr(ctx_clr), .req_valid(req_valid),
    .req_ready(rdy[0]), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rv[0]), .rsp_fail(rf[0]), .mem_wr_en(we[0]), .excl_held(eh[0])
  );

  excl_mon #(.GRAN_SHIFT(3), .MISMATCH_WRITES(1'b1), .PLAIN_ST_CLEARS(1'b0)) u1 (
    .clk(clk), .rst(rst), .ctx_clr(ctx_clr), .req_valid(req_valid),
    .req_ready(rdy[1]), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rv[1]), .rsp_fail(rf[1]), .mem_wr_en(we[1]), .excl_held(eh[1])
  );

  task automatic step(input bit v, input bit c, input int op, input longint a, input string rq);
    @(negedge clk);
    req_valid = v; ctx_clr = c; req_op = 2'(op); req_addr = 32'(a);
    #2;
    for (int k = 0; k < 2; k++) begin
      bit     acc = v && !c;
      longint t   = a >> gs[k];
      bit     mt  = m_excl[k] && (t == m_tag[k]);
      bit     e_rv = acc && op == 1;
      bit     e_rf = e_rv && !mt;
      bit     e_we = e_rv && (mt || (m_excl[k] && mw[k]));
      bit     e_rdy = !c;
      n_cmp++;
      if (rdy[k] !== e_rdy || rv[k] !== e_rv || rf[k] !== e_rf || we[k] !== e_we || eh[k] !== m_excl[k]) begin
        n_bad++;
        $display("FAIL %s inst%0d: rdy/rv/rf/we/held got %b%b%b%b%b expected %b%b%b%b%b",
                 rq, k, rdy[k], rv[k], rf[k], we[k], eh[k], e_rdy, e_rv, e_rf, e_we, m_excl[k]);
      end
      if (c) m_excl[k] = 0;
      else if (acc) begin
        case (op)
          0: begin m_excl[k] = 1; m_tag[k] = t; end
          1: m_excl[k] = 0;
          2: if (mt && psc[k]) m_excl[k] = 0;
          default: m_excl[k] = 0;
        endcase
      end
    end
  endtask

  initial begin
    rst = 1; ctx_clr = 0; req_valid = 0; req_op = 0; req_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    for (int k = 0; k < 2; k++) begin m_excl[k] = 0; m_tag[k] = 0; end
    step(0, 0, 0, 0, "R1");                          // reset state
    step(1, 0, 1, 0, "R1");                          // stex to 0 after reset fails
    step(1, 0, 0, 'h341B4, "R3");                    // ldex
    step(1, 0, 1, 'h341BC, "R4");                    // u0 hit, u1 mismatch (R5)
    step(1, 0, 1, 'h341BC, "R6");                    // open stex
    step(1, 0, 0, 'h341B4, "R3");
    step(1, 0, 1, 'h34200, "R5");                    // mismatch
    step(1, 0, 0, 'h341B4, "R3");
    step(1, 0, 2, 'h50000, "R7");                    // store outside
    step(1, 0, 1, 'h341B0, "R4");
    step(1, 0, 0, 'h341B4, "R3");
    step(1, 0, 2, 'h341B0, "R8");                    // store inside
    step(1, 0, 1, 'h341B0, "R8");
    step(1, 0, 0, 'h341B4, "R10");
    step(1, 0, 0, 'h40000, "R10");                   // replace tag
    step(1, 0, 1, 'h341B4, "R10");
    step(1, 0, 0, 'h40004, "R10");
    step(1, 0, 1, 'h40004, "R10");
    step(1, 0, 0, 'h341B4, "R9");
    step(1, 1, 0, 'h341B4, "R9");                    // clear beats request
    step(1, 0, 1, 'h341B4, "R9");
    step(1, 0, 0, 'h341B4, "R11");
    step(1, 0, 3, 0, "R11");
    step(1, 0, 1, 'h341B4, "R11");
    step(1, 0, 0, 'h341B4, "R2");
    step(0, 0, 1, 'h341B4, "R2");                    // not valid: ignored
    step(0, 0, 3, 'h341B4, "R2");
    step(1, 0, 1, 'h341B4, "R2");
    for (int i = 0; i < 400; i++)
      step(($urandom % 5) != 0, ($urandom % 13) == 0, $urandom % 4,
           'h341A0 + ($urandom % 64), "R12");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule